// File: doc/BRIEF.md
# MDIO bridge for 32-bit registers

This block lets a host reach a 32-bit register file that sits behind a Clause-22 MDIO management port. A register is named by a 16-bit byte address. Since registers are word aligned, the two lowest address bits carry no meaning. The ten upper bits choose a page and the four bits below them choose a word inside that page. The 16-bit data field of a Clause-22 frame can carry only half a register, so each host access becomes three chained frames. The first frame is a write that selects the page. The second frame moves the low half and carries the in-page word index. The third frame moves the high half.

The host side is a request/acknowledge handshake. The host holds `req_valid` high, together with the address, the direction flag and the write data, until it sees a one-cycle `req_ack`. After a read, `rd_data` holds the 32-bit result until the next read completes. On the line side, the block makes MDC from the system clock with a divider and drives MDIO through a split output / output-enable / input pin set. It releases the line during the turnaround and data bits of read frames.

Top module: `mdio_reg32_bridge`

## Requirements
- R1: While reset is held and just after it: `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 1, `req_ack` is 0 and `rd_data` is 0.
- R2: `mdc` is a free-running square wave, high for DIV_HALF clocks and low for DIV_HALF clocks. `mdio_o` and `mdio_oe` change only in the clock cycles in which `mdc` falls.
- R3: Every frame is sent MSB first on `mdio_o` in this order: PRE_LEN one bits, start code 01, a 2-bit opcode (01 = write, 10 = read), a 5-bit device field equal to `dev_addr` as sampled when the request was accepted, and a 5-bit register field. A write frame continues with turnaround 10 and 16 data bits.
- R4: The first frame of every access, read or write, is a write with register field 11111 and data {6'b0, req_addr[15:6]}.
- R5: The second frame has register field {1'b0, req_addr[5:2]}. The third frame has register field 10000. Both frames use the access's opcode.
- R6: For a write access, the data of the second frame is req_wdata[15:0] and the data of the third frame is req_wdata[31:16].
- R7: In the read frames, `mdio_oe` is 0 from the first turnaround bit through the last data bit. The bits on `mdio_i` at the 16 rising `mdc` edges that follow the turnaround are the data, MSB first. `rd_data` becomes {third-frame data, second-frame data}.
- R8: req_addr[1:0] has no effect: the frames for all four values of these bits are identical.
- R9: `req_ack` is high for exactly one clock after the third frame ends, with `mdio_oe` low. `rd_data` changes only in an acknowledge cycle of a read, so a write leaves it unchanged.
- R10: Each accepted request produces exactly three frames, even though `req_valid` stays high during the whole access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request, held until `req_ack` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 16 | Register byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| dev_addr | input | 5 | Device field for the frames, usually 5'h1f |
| req_ack | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the bridge with DIV_HALF = 2 and the standard 32-bit preamble, so one frame takes only 256 system clocks. This keeps a sweep affordable that covers all sixteen in-page word indices, for both reads and writes, each with its own computed page. Further sweeps cover several device-field values and all four low address bits. A bus model in the bench decodes every frame bit by bit, and for reads it returns halves derived arithmetically from the address. This brings the preamble length, every field position, the turnaround ownership and the assembly of the 32-bit result within reach of direct comparison.

// File: rtl/mdio_br_pkg.sv
package mdio_br_pkg;

    localparam int REG_ADDR_W  = 16;
    localparam int REG_DATA_W  = 32;
    localparam int HALF_W      = REG_DATA_W / 2;
    localparam int PAGE_LSB    = 6;
    localparam int PAGE_W      = REG_ADDR_W - PAGE_LSB;
    localparam int WORD_LSB    = 2;
    localparam int WORD_W      = PAGE_LSB - WORD_LSB;
    localparam int DEV_W       = 5;
    localparam int FIELD_W     = 5;

    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] START_SEQ = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;
    localparam logic [1:0] TA_READ   = 2'b11;

    localparam logic [FIELD_W-1:0] FIELD_PAGE = 5'b11111;
    localparam logic [FIELD_W-1:0] FIELD_HIGH = 5'b10000;

    typedef enum logic [1:0] {
        PH_PAGE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        logic                          busy;
        phase_e                        phase;
        logic                          start;
        logic                          write;
        logic [REG_ADDR_W-1:WORD_LSB]  waddr;
        logic [REG_DATA_W-1:0]         wdata;
        logic [DEV_W-1:0]              dev;
        logic [HALF_W-1:0]             rd_lo;
        logic [REG_DATA_W-1:0]         rd_data;
        logic                          ack;
    } seq_st_t;

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic rise_now,
    output logic fall_now
);
    localparam int CNT_W = $clog2(DIV_HALF + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_st_t;

    gen_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == CNT_W'(DIV_HALF - 1));
        if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mdc      = st_q.mdc;
    assign rise_now = wrap & ~st_q.mdc;
    assign fall_now = wrap &  st_q.mdc;

endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_br_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_now,
    input  logic               fall_now,
    input  logic               start,
    input  logic               is_read,
    input  logic [DEV_W-1:0]   dev,
    input  logic [FIELD_W-1:0] field,
    input  logic [HALF_W-1:0]  wdata,
    input  logic               mdio_i,
    output logic               done,
    output logic [HALF_W-1:0]  rdata,
    output logic               mdio_o,
    output logic               mdio_oe
);
    localparam int FRAME_BITS = PRE_LEN + 32;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);
    localparam int TA_POS     = PRE_LEN + 14;
    localparam int DAT_POS    = PRE_LEN + 16;

    typedef struct packed {
        logic                  active;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
        logic [HALF_W-1:0]     cap;
        logic                  dout;
        logic                  oe;
        logic                  done;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.rd     = is_read;
                st_d.idx    = '0;
                st_d.sh     = {{PRE_LEN{1'b1}}, START_SEQ,
                               is_read ? OPC_READ : OPC_WRITE,
                               dev, field,
                               is_read ? TA_READ : TA_WRITE,
                               is_read ? {HALF_W{1'b0}} : wdata};
            end
        end else if (fall_now) begin
            if (st_q.idx == IDX_W'(FRAME_BITS)) begin
                st_d.active = 1'b0;
                st_d.done   = 1'b1;
                st_d.oe     = 1'b0;
                st_d.dout   = 1'b1;
            end else begin
                st_d.dout = st_q.sh[FRAME_BITS-1];
                st_d.sh   = {st_q.sh[FRAME_BITS-2:0], 1'b1};
                st_d.oe   = !(st_q.rd && (st_q.idx >= IDX_W'(TA_POS)));
                st_d.idx  = st_q.idx + 1'b1;
            end
        end else if (rise_now) begin
            if (st_q.rd && (st_q.idx > IDX_W'(DAT_POS))) begin
                st_d.cap = {st_q.cap[HALF_W-2:0], mdio_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.dout <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign done    = st_q.done;
    assign rdata   = st_q.cap;
    assign mdio_o  = st_q.dout;
    assign mdio_oe = st_q.oe;

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
    import mdio_br_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [REG_DATA_W-1:0] req_wdata,
    input  logic [DEV_W-1:0]      dev_addr,
    input  logic                  eng_done,
    input  logic [HALF_W-1:0]     eng_rdata,
    output logic                  f_start,
    output logic                  f_read,
    output logic [DEV_W-1:0]      f_dev,
    output logic [FIELD_W-1:0]    f_field,
    output logic [HALF_W-1:0]     f_wdata,
    output logic                  req_ack,
    output logic [REG_DATA_W-1:0] rd_data
);
    seq_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.ack   = 1'b0;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.phase = PH_PAGE;
                st_d.start = 1'b1;
                st_d.write = req_write;
                st_d.waddr = req_addr[REG_ADDR_W-1:WORD_LSB];
                st_d.wdata = req_wdata;
                st_d.dev   = dev_addr;
            end
        end else if (eng_done) begin
            case (st_q.phase)
                PH_PAGE: begin
                    st_d.phase = PH_LOW;
                    st_d.start = 1'b1;
                end
                PH_LOW: begin
                    st_d.rd_lo = eng_rdata;
                    st_d.phase = PH_HIGH;
                    st_d.start = 1'b1;
                end
                default: begin
                    st_d.busy = 1'b0;
                    st_d.ack  = 1'b1;
                    if (!st_q.write) begin
                        st_d.rd_data = {eng_rdata, st_q.rd_lo};
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        f_read = !st_q.write && (st_q.phase != PH_PAGE);
        case (st_q.phase)
            PH_PAGE: begin
                f_field = FIELD_PAGE;
                f_wdata = HALF_W'(st_q.waddr[REG_ADDR_W-1:PAGE_LSB]);
            end
            PH_LOW: begin
                f_field = {1'b0, st_q.waddr[PAGE_LSB-1:WORD_LSB]};
                f_wdata = st_q.wdata[HALF_W-1:0];
            end
            default: begin
                f_field = FIELD_HIGH;
                f_wdata = st_q.wdata[REG_DATA_W-1:HALF_W];
            end
        endcase
    end

    assign f_start = st_q.start;
    assign f_dev   = st_q.dev;
    assign req_ack = st_q.ack;
    assign rd_data = st_q.rd_data;

endmodule

// File: rtl/mdio_reg32_bridge.sv
module mdio_reg32_bridge
    import mdio_br_pkg::*;
#(
    parameter int DIV_HALF = 10,
    parameter int PRE_LEN  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [REG_ADDR_W-1:0] req_addr,
    input  logic [REG_DATA_W-1:0] req_wdata,
    input  logic [DEV_W-1:0]      dev_addr,
    output logic                  req_ack,
    output logic [REG_DATA_W-1:0] rd_data,
    output logic                  mdc,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    input  logic                  mdio_i
);
    logic               rise_now, fall_now;
    logic               f_start, f_read, eng_done;
    logic [DEV_W-1:0]   f_dev;
    logic [FIELD_W-1:0] f_field;
    logic [HALF_W-1:0]  f_wdata, eng_rdata;

    mdio_mdc_gen #(.DIV_HALF(DIV_HALF)) i_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    mdio_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dev_addr  (dev_addr),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata),
        .f_start   (f_start),
        .f_read    (f_read),
        .f_dev     (f_dev),
        .f_field   (f_field),
        .f_wdata   (f_wdata),
        .req_ack   (req_ack),
        .rd_data   (rd_data)
    );

    mdio_frame_eng #(.PRE_LEN(PRE_LEN)) i_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_now (rise_now),
        .fall_now (fall_now),
        .start    (f_start),
        .is_read  (f_read),
        .dev      (f_dev),
        .field    (f_field),
        .wdata    (f_wdata),
        .mdio_i   (mdio_i),
        .done     (eng_done),
        .rdata    (eng_rdata),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

endmodule

// File: rtl/mdio_bridge_chk.sv
module mdio_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        req_ack,
    input logic [31:0] rd_data
);
    // R2
    dout_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_o) |-> $fell(mdc));

    // R2
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_oe) |-> $fell(mdc));

    // R9
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R9
    ack_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> !mdio_oe);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> req_ack);

endmodule

bind mdio_reg32_bridge mdio_bridge_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .req_ack (req_ack),
    .rd_data (rd_data)
);

// File: tb/test_mdio_reg32_bridge.sv
`timescale 1ns/1ps
module test_mdio_reg32_bridge;
    localparam int DIVH = 2;
    localparam int PRE  = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [4:0]  dev_addr = 5'h1f;
    logic        req_ack;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] tb_rd_lo, tb_rd_hi;
    int          mon_cnt;
    int          m_pre  [4];
    logic        m_st1  [4];
    logic [1:0]  m_op   [4];
    logic [4:0]  m_dev  [4];
    logic [4:0]  m_fld  [4];
    logic [1:0]  m_ta   [4];
    logic [15:0] m_dat  [4];
    logic        m_oebad[4];

    always #10 clk = ~clk;

    mdio_reg32_bridge #(.DIV_HALF(DIVH), .PRE_LEN(PRE)) i_mdio_reg32_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dev_addr  (dev_addr),
        .req_ack   (req_ack),
        .rd_data   (rd_data),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus model: decodes frames, answers reads
    initial begin
        int run;
        run = 0;
        mdio_i = 1'b1;
        mon_cnt = 0;
        forever begin
            @(posedge mdc);
            if (!mdio_oe) run = 0;
            else if (mdio_o) run++;
            else if (run >= PRE) begin
                int          pre, slot;
                logic        st1, oe_bad;
                logic [11:0] hdr;
                logic [17:0] tail;
                logic [15:0] src;
                pre = run;
                run = 0;
                hdr = '0;
                tail = '0;
                oe_bad = 1'b0;
                @(posedge mdc);
                st1 = mdio_o;
                for (int i = 0; i < 12; i++) begin
                    @(posedge mdc);
                    hdr = {hdr[10:0], mdio_o};
                end
                if (hdr[11:10] == 2'b10) begin
                    src = hdr[4] ? tb_rd_hi : tb_rd_lo;
                    for (int i = 0; i < 18; i++) begin
                        @(negedge mdc);
                        if (i == 0) mdio_i = 1'b1;
                        else if (i == 1) mdio_i = 1'b0;
                        else mdio_i = src[17-i];
                        @(posedge mdc);
                        if (mdio_oe) oe_bad = 1'b1;
                    end
                    tail = {2'b00, src};
                    @(negedge mdc);
                    mdio_i = 1'b1;
                end else begin
                    for (int i = 0; i < 18; i++) begin
                        @(posedge mdc);
                        tail = {tail[16:0], mdio_o};
                        if (!mdio_oe) oe_bad = 1'b1;
                    end
                end
                slot = (mon_cnt < 4) ? mon_cnt : 3;
                m_pre[slot]   = pre;
                m_st1[slot]   = st1;
                m_op[slot]    = hdr[11:10];
                m_dev[slot]   = hdr[9:5];
                m_fld[slot]   = hdr[4:0];
                m_ta[slot]    = tail[17:16];
                m_dat[slot]   = tail[15:0];
                m_oebad[slot] = oe_bad;
                mon_cnt++;
            end else run = 0;
        end
    end

    task automatic access(input logic wr, input logic [15:0] addr, input logic [31:0] wd,
                          input logic [4:0] dev, input logic [15:0] lo, input logic [15:0] hi);
        logic [31:0] prev;
        logic [1:0]  opx;
        prev = rd_data;
        tb_rd_lo = lo;
        tb_rd_hi = hi;
        mon_cnt = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_wdata = wd;
        dev_addr  = dev;
        @(negedge clk);
        while (!req_ack) @(negedge clk);
        req_valid = 1'b0;
        dev_addr  = ~dev;
        @(negedge clk);
        check("R9 ack one cycle", {63'd0, req_ack}, 64'd0);
        check("R10 three frames", mon_cnt, 3);
        opx = wr ? 2'b01 : 2'b10;
        for (int f = 0; f < 3; f++) begin
            check("R3 preamble length", m_pre[f], PRE);
            check("R3 start code", {m_st1[f]}, 1);
            check("R3 device field", m_dev[f], dev);
        end
        check("R4 page frame opcode", m_op[0], 2'b01);
        check("R4 page frame field", m_fld[0], 5'b11111);
        check("R3 page frame turnaround", m_ta[0], 2'b10);
        check("R4 page frame data", m_dat[0], {6'b0, addr[15:6]});
        check("R5 low frame opcode", m_op[1], opx);
        check("R5 low frame field", m_fld[1], {1'b0, addr[5:2]});
        check("R5 high frame opcode", m_op[2], opx);
        check("R5 high frame field", m_fld[2], 5'b10000);
        if (wr) begin
            check("R6 low turnaround", m_ta[1], 2'b10);
            check("R6 low data", m_dat[1], wd[15:0]);
            check("R6 high turnaround", m_ta[2], 2'b10);
            check("R6 high data", m_dat[2], wd[31:16]);
            check("R6 driven throughout", {m_oebad[1], m_oebad[2]}, 0);
            check("R9 write keeps rd_data", rd_data, prev);
        end else begin
            check("R7 released low frame", {m_oebad[1]}, 0);
            check("R7 released high frame", {m_oebad[2]}, 0);
            check("R7 read data", rd_data, {hi, lo});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lo_n, hi_n;
        logic [9:0]  pg;
        logic [15:0] ad;
        repeat (5) @(negedge clk);
        check("R1 reset mdc", {mdc}, 0);
        check("R1 reset oe", {mdio_oe}, 0);
        check("R1 reset dout", {mdio_o}, 1);
        check("R1 reset ack", {req_ack}, 0);
        check("R1 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset oe", {mdio_oe}, 0);
        check("R1 after reset rd_data", rd_data, 0);

        while (mdc == 1'b0) @(negedge clk);
        while (mdc == 1'b1) @(negedge clk);
        lo_n = 0;
        while (mdc == 1'b0) begin lo_n++; @(negedge clk); end
        hi_n = 0;
        while (mdc == 1'b1) begin hi_n++; @(negedge clk); end
        check("R2 mdc low time", lo_n, DIVH);
        check("R2 mdc high time", hi_n, DIVH);

        for (int w = 0; w < 16; w++) begin
            pg = 10'((w * 97 + 5) % 1024);
            ad = {pg, 4'(w), 2'(w)};
            access(1'b1, ad, {16'(w * 4099 + 1), 16'(w * 777 + 3)}, 5'h1f, 16'h0, 16'h0);
            pg = 10'((w * 211 + 1000) % 1024);
            ad = {pg, 4'(15 - w), 2'b00};
            access(1'b0, ad, 32'h0, 5'h1f, 16'(w * 2503 + 17), 16'(w * 1201 + 9));
        end
        for (int d = 0; d < 32; d += 5) begin
            access(1'b0, 16'h5a5c, 32'h0, 5'(d), 16'(d * 301), 16'(~(d * 13)));
        end
        access(1'b1, 16'hffc4, 32'hdead_beef, 5'h1f, 16'h0, 16'h0);
        for (int s = 0; s < 4; s++) begin
            // R8: low address bits vary, frames must stay the same
            access(1'b0, {14'h2d1b, 2'(s)}, 32'h0, 5'h1f, 16'h1234, 16'habcd);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule